// File: doc/BRIEF.md
# Floating-Point Register Result Status Table

This block is the rename table that sits beside a floating-point register file of sixteen even-numbered registers, F0, F2 and so on up to F30. For every register it keeps a pending flag, the tag of the station that will produce the register's next value, and the last value delivered. Register index k on every port stands for register F(2k). A register number matters only at issue. The issue stage presents two source register numbers and gets back, for each one, either a ready value or the tag of the pending producer. In the same cycle it may name a destination register and the tag of the station that will write it.

Once a tag has been assigned, results are routed by tag alone. A result broadcast carries a tag and a value. Every pending register whose recorded tag equals the broadcast tag takes the value and becomes ready. When a later instruction names the same destination, its tag replaces the earlier one. A late result from the earlier producer then leaves the register untouched, so write-after-write ordering needs no stall. Sources are copied at issue, so write-after-read ordering needs no stall either. Lookups are combinational and see a broadcast of the same cycle.

Top module: `fp_result_status`

## Requirements
- R1: After reset every register is not pending: a lookup returns ready=1, tag=0 and value=0.
- R2: An issue with `issue_valid`=1 and `issue_dst_valid`=1 marks register `issue_dst_reg` pending with tag `issue_dst_tag` from the next cycle. A lookup of a pending register returns ready=0, the pending tag and value=0.
- R3: A broadcast (`res_valid`=1) whose tag equals a pending register's tag writes `res_value` into that register and clears its pending flag from the next cycle. A later lookup returns ready=1, tag=0 and that value.
- R4: A single broadcast updates every pending register whose tag matches it, in the same cycle.
- R5: A broadcast has no effect on a register that is not pending, or whose pending tag differs from the broadcast tag. The register's lookup result is unchanged.
- R6: A second issue to a register that is already pending replaces its tag. A broadcast of the replaced tag then leaves the register pending with the newer tag.
- R7: When an issue assigns a register in the same cycle that a matching broadcast would clear it, the issue wins. The register is pending with the new tag in the next cycle.
- R8: A lookup of a pending register, in a cycle where the broadcast tag matches its pending tag, returns ready=1, tag=0 and the broadcast value in that same cycle.
- R9: Lookups reflect the table before the current cycle's issue. A source that names the destination of the same issue returns the prior state of that register.
- R10: No change to the table occurs from the destination fields when `issue_valid`=0 or `issue_dst_valid`=0.
- R11: The two source lookups are independent and both combinational. Each returns the state of its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_dst_valid | input | 1 | The issuing instruction writes a register |
| issue_dst_reg | input | 4 | Destination register index (k means F(2k)) |
| issue_dst_tag | input | 4 | Tag of the station producing the destination |
| src_a_reg | input | 4 | First source register index |
| src_a_ready | output | 1 | First source value is available |
| src_a_tag | output | 4 | Producer tag of the first source when not ready, else 0 |
| src_a_value | output | 64 | First source value when ready, else 0 |
| src_b_reg | input | 4 | Second source register index |
| src_b_ready | output | 1 | Second source value is available |
| src_b_tag | output | 4 | Producer tag of the second source when not ready, else 0 |
| src_b_value | output | 64 | Second source value when ready, else 0 |
| res_valid | input | 1 | A result is broadcast this cycle |
| res_tag | input | 4 | Tag of the broadcast result |
| res_value | input | 64 | Value of the broadcast result |

## Verification
Directed sequences come first. One assigns every register a distinct tag and then clears the registers one at a time, which separates per-register state from shared state. A shared tag across several registers shows that a broadcast fans out to all matches. Further sequences cover re-issue, a broadcast to an idle register and a mismatching tag, which tell apart a correct tag comparison from one that tests only the pending flag. Single cycles then exercise the same-cycle collisions: issue against broadcast, a lookup against broadcast, and a lookup against a destination. A long pseudo-random stream follows, in which half of the broadcasts aim at a live tag. In every cycle all sixteen registers are swept through both lookup ports and compared with an arithmetic model.

// File: rtl/fprs_pkg.sv
package fprs_pkg;
  localparam int unsigned FPRS_REGS  = 16;
  localparam int unsigned FPRS_TAG_W = 4;
  localparam int unsigned FPRS_VAL_W = 64;
endpackage

// File: rtl/fprs_dst_decode.sv
module fprs_dst_decode #(
  parameter int unsigned REGS  = fprs_pkg::FPRS_REGS,
  localparam int unsigned IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             dst_valid,
  input  logic [IDX_W-1:0] dst_reg,
  output logic [REGS-1:0]  set_en
);
  logic write_now;

  assign write_now = issue_valid & dst_valid;

  for (genvar i = 0; i < REGS; i++) begin : g_dec
    assign set_en[i] = write_now && (dst_reg == IDX_W'(i));
  end

  // R10: nothing is selected without a valid destination write
  a_r10_no_write_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && dst_valid) |-> (set_en == '0));

  a_r2_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_en));
endmodule

// File: rtl/fprs_entry.sv
module fprs_entry #(
  parameter int unsigned TAG_W = fprs_pkg::FPRS_TAG_W,
  parameter int unsigned VAL_W = fprs_pkg::FPRS_VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic [VAL_W-1:0] res_value,
  output logic             busy_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [VAL_W-1:0] value_o
);
  logic             busy_q, busy_d, busy_en;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             tag_en;
  logic [VAL_W-1:0] value_q, value_d;
  logic             value_en;
  logic             hit;

  // next-state logic
  always_comb begin
    hit      = res_valid && busy_q && (tag_q == res_tag);
    tag_en   = set_en;
    tag_d    = set_tag;
    value_en = hit;
    value_d  = res_value;
    busy_en  = set_en || hit;
    busy_d   = set_en;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (value_en) begin
      value_q <= value_d;
    end
  end

  assign busy_o  = busy_q;
  assign tag_o   = tag_q;
  assign value_o = value_q;

  a_r2_issue_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (busy_q && tag_q == $past(set_tag)));

  a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && res_valid && busy_q && tag_q == res_tag)
      |=> (!busy_q && value_q == $past(res_value)));

  a_r5_no_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !(res_valid && busy_q && tag_q == res_tag))
      |=> ($stable(busy_q) && $stable(tag_q) && $stable(value_q)));

  a_r7_issue_beats_result: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && res_valid && busy_q && tag_q == res_tag)
      |=> (busy_q && tag_q == $past(set_tag)));
endmodule

// File: rtl/fprs_lookup.sv
module fprs_lookup #(
  parameter int unsigned REGS  = fprs_pkg::FPRS_REGS,
  parameter int unsigned TAG_W = fprs_pkg::FPRS_TAG_W,
  parameter int unsigned VAL_W = fprs_pkg::FPRS_VAL_W,
  localparam int unsigned IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel,
  input  logic [REGS-1:0]  busy_vec,
  input  logic [TAG_W-1:0] tag_arr [REGS],
  input  logic [VAL_W-1:0] val_arr [REGS],
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic [VAL_W-1:0] res_value,
  output logic             ready,
  output logic [TAG_W-1:0] tag,
  output logic [VAL_W-1:0] value
);
  logic             sel_busy;
  logic [TAG_W-1:0] sel_tag;
  logic [VAL_W-1:0] sel_val;
  logic             bypass;

  always_comb begin
    sel_busy = busy_vec[sel];
    sel_tag  = tag_arr[sel];
    sel_val  = val_arr[sel];
    bypass   = sel_busy && res_valid && (res_tag == sel_tag);
    if (!sel_busy) begin
      ready = 1'b1;
      tag   = '0;
      value = sel_val;
    end else if (bypass) begin
      ready = 1'b1;
      tag   = '0;
      value = res_value;
    end else begin
      ready = 1'b0;
      tag   = sel_tag;
      value = '0;
    end
  end

  a_r8_same_cycle_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec[sel] && res_valid && res_tag == tag_arr[sel])
      |-> (ready && value == res_value && tag == '0));

  a_r2_pending_gives_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec[sel] && !(res_valid && res_tag == tag_arr[sel]))
      |-> (!ready && tag == tag_arr[sel] && value == '0));

  a_r1_idle_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_vec[sel] |-> (ready && tag == '0));
endmodule

// File: rtl/fp_result_status.sv
module fp_result_status #(
  parameter int unsigned REGS  = fprs_pkg::FPRS_REGS,
  parameter int unsigned TAG_W = fprs_pkg::FPRS_TAG_W,
  parameter int unsigned VAL_W = fprs_pkg::FPRS_VAL_W,
  localparam int unsigned IDX_W = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             issue_dst_valid,
  input  logic [IDX_W-1:0] issue_dst_reg,
  input  logic [TAG_W-1:0] issue_dst_tag,
  input  logic [IDX_W-1:0] src_a_reg,
  output logic             src_a_ready,
  output logic [TAG_W-1:0] src_a_tag,
  output logic [VAL_W-1:0] src_a_value,
  input  logic [IDX_W-1:0] src_b_reg,
  output logic             src_b_ready,
  output logic [TAG_W-1:0] src_b_tag,
  output logic [VAL_W-1:0] src_b_value,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic [VAL_W-1:0] res_value
);
  logic [REGS-1:0]  set_en;
  logic [REGS-1:0]  busy_vec;
  logic [TAG_W-1:0] tag_arr [REGS];
  logic [VAL_W-1:0] val_arr [REGS];

  fprs_dst_decode #(.REGS(REGS)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .dst_valid   (issue_dst_valid),
    .dst_reg     (issue_dst_reg),
    .set_en      (set_en)
  );

  for (genvar i = 0; i < REGS; i++) begin : g_reg
    fprs_entry #(.TAG_W(TAG_W), .VAL_W(VAL_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en[i]),
      .set_tag   (issue_dst_tag),
      .res_valid (res_valid),
      .res_tag   (res_tag),
      .res_value (res_value),
      .busy_o    (busy_vec[i]),
      .tag_o     (tag_arr[i]),
      .value_o   (val_arr[i])
    );
  end

  fprs_lookup #(.REGS(REGS), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_look_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (src_a_reg),
    .busy_vec  (busy_vec),
    .tag_arr   (tag_arr),
    .val_arr   (val_arr),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_value (res_value),
    .ready     (src_a_ready),
    .tag       (src_a_tag),
    .value     (src_a_value)
  );

  fprs_lookup #(.REGS(REGS), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_look_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (src_b_reg),
    .busy_vec  (busy_vec),
    .tag_arr   (tag_arr),
    .val_arr   (val_arr),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_value (res_value),
    .ready     (src_b_ready),
    .tag       (src_b_tag),
    .value     (src_b_value)
  );

  // R11: identical selections through both ports agree
  a_r11_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_reg == src_b_reg) |->
      (src_a_ready == src_b_ready && src_a_tag == src_b_tag && src_a_value == src_b_value));

  // R6: a pending register stays pending across an issue to it
  a_r6_reissue_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_dst_valid) |=> busy_vec[$past(issue_dst_reg)]);
endmodule

// File: tb/fp_result_status_test.sv
`timescale 1ns/1ps
module fp_result_status_test;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, issue_dst_valid;
  logic [3:0]  issue_dst_reg, issue_dst_tag;
  logic [3:0]  src_a_reg, src_b_reg;
  logic        src_a_ready, src_b_ready;
  logic [3:0]  src_a_tag, src_b_tag;
  logic [63:0] src_a_value, src_b_value;
  logic        res_valid;
  logic [3:0]  res_tag;
  logic [63:0] res_value;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic        m_busy [NR];
  logic [3:0]  m_tag  [NR];
  logic [63:0] m_val  [NR];

  always #2.5 clk = ~clk;

  fp_result_status uut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_dst_valid(issue_dst_valid),
    .issue_dst_reg(issue_dst_reg), .issue_dst_tag(issue_dst_tag),
    .src_a_reg(src_a_reg), .src_a_ready(src_a_ready),
    .src_a_tag(src_a_tag), .src_a_value(src_a_value),
    .src_b_reg(src_b_reg), .src_b_ready(src_b_ready),
    .src_b_tag(src_b_tag), .src_b_value(src_b_value),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value)
  );

  task automatic compare(input string req, input int k, input string port,
                         input logic rdy, input logic [3:0] tg, input logic [63:0] v);
    logic        e_rdy;
    logic [3:0]  e_tg;
    logic [63:0] e_v;
    if (!m_busy[k]) begin
      e_rdy = 1'b1; e_tg = 4'd0; e_v = m_val[k];
    end else if (res_valid && res_tag == m_tag[k]) begin
      e_rdy = 1'b1; e_tg = 4'd0; e_v = res_value;
    end else begin
      e_rdy = 1'b0; e_tg = m_tag[k]; e_v = 64'd0;
    end
    tests++;
    if (rdy !== e_rdy || tg !== e_tg || v !== e_v) begin
      fails++;
      $display("FAIL %s F%0d port %s: got ready=%b tag=%0d value=%h, expected ready=%b tag=%0d value=%h",
               req, 2*k, port, rdy, tg, v, e_rdy, e_tg, e_v);
    end
  endtask

  // one cycle: drive, sweep lookups before the edge, clock, update model
  task automatic cyc(input string req, input logic iv, input logic dv,
                     input logic [3:0] didx, input logic [3:0] dtag,
                     input logic bv, input logic [3:0] btag, input logic [63:0] bval);
    issue_valid = iv; issue_dst_valid = dv; issue_dst_reg = didx; issue_dst_tag = dtag;
    res_valid = bv; res_tag = btag; res_value = bval;
    for (int k = 0; k < NR; k++) begin
      src_a_reg = 4'(k);
      src_b_reg = 4'(NR - 1 - k);
      #0.1;
      compare(req, k, "a", src_a_ready, src_a_tag, src_a_value);
      compare(req, NR - 1 - k, "b", src_b_ready, src_b_tag, src_b_value);
    end
    @(posedge clk);
    for (int k = 0; k < NR; k++) begin
      if (iv && dv && didx == 4'(k)) begin
        if (bv && m_busy[k] && m_tag[k] == btag) m_val[k] = bval;
        m_busy[k] = 1'b1;
        m_tag[k]  = dtag;
      end else if (bv && m_busy[k] && m_tag[k] == btag) begin
        m_busy[k] = 1'b0;
        m_val[k]  = bval;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    cyc(req, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 64'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0;
    issue_valid = 0; issue_dst_valid = 0; issue_dst_reg = 0; issue_dst_tag = 0;
    res_valid = 0; res_tag = 0; res_value = 0; src_a_reg = 0; src_b_reg = 0;
    for (int k = 0; k < NR; k++) begin
      m_busy[k] = 1'b0; m_tag[k] = 4'd0; m_val[k] = 64'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    idle("R1");

    // R2: every register gets its own tag; R11 both ports sweep them
    for (int k = 0; k < NR; k++)
      cyc("R2", 1'b1, 1'b1, 4'(k), 4'(15 - k), 1'b0, 4'd0, 64'd0);
    idle("R11");

    // R3: clear registers one by one by tag
    for (int k = 0; k < NR; k++)
      cyc("R3", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'(15 - k), 64'h1111_0000_0000_0000 * 64'(k) + 64'd7);
    idle("R3");

    // R4: one tag shared by three registers
    cyc("R4", 1'b1, 1'b1, 4'd1, 4'd9, 1'b0, 4'd0, 64'd0);
    cyc("R4", 1'b1, 1'b1, 4'd3, 4'd9, 1'b0, 4'd0, 64'd0);
    cyc("R4", 1'b1, 1'b1, 4'd5, 4'd9, 1'b0, 4'd0, 64'd0);
    cyc("R4", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd9, 64'hDEAD_BEEF_0000_0009);
    idle("R4");

    // R5: broadcast to nobody, and a mismatching tag
    cyc("R5", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd12, 64'hAAAA);
    cyc("R5", 1'b1, 1'b1, 4'd2, 4'd3, 1'b0, 4'd0, 64'd0);
    cyc("R5", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd4, 64'hBBBB);
    idle("R5");

    // R6: re-issue replaces tag, old result ignored
    cyc("R6", 1'b1, 1'b1, 4'd6, 4'd1, 1'b0, 4'd0, 64'd0);
    cyc("R6", 1'b1, 1'b1, 4'd6, 4'd2, 1'b0, 4'd0, 64'd0);
    cyc("R6", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd1, 64'h0101);
    idle("R6");
    cyc("R6", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd2, 64'h0202);
    idle("R6");

    // R7: issue and matching broadcast collide on one register
    cyc("R7", 1'b1, 1'b1, 4'd7, 4'd5, 1'b0, 4'd0, 64'd0);
    cyc("R7", 1'b1, 1'b1, 4'd7, 4'd6, 1'b1, 4'd5, 64'h0505);
    idle("R7");

    // R8: same-cycle bypass (checked inside the sweep of this cycle)
    cyc("R8", 1'b1, 1'b1, 4'd8, 4'd10, 1'b0, 4'd0, 64'd0);
    cyc("R8", 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd10, 64'h0A0A_0A0A);
    idle("R8");

    // R9: destination of this issue looked up in the same cycle
    cyc("R9", 1'b1, 1'b1, 4'd9, 4'd11, 1'b0, 4'd0, 64'd0);
    cyc("R9", 1'b1, 1'b1, 4'd9, 4'd12, 1'b0, 4'd0, 64'd0);
    idle("R9");

    // R10: destination fields without a valid write
    cyc("R10", 1'b0, 1'b1, 4'd0, 4'd15, 1'b0, 4'd0, 64'd0);
    cyc("R10", 1'b1, 1'b0, 4'd4, 4'd14, 1'b0, 4'd0, 64'd0);
    idle("R10");

    // pseudo-random stream covering R2 R3 R5 R6 R7 R8 R9
    lf = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      logic [3:0] bt;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      bt = lf[15] ? m_tag[lf[14:11]] : lf[19:16];
      cyc("R2_R3_R8_mix", lf[0], lf[1], lf[5:2], lf[9:6], lf[10], bt,
          {lf, ~lf} ^ 64'(n));
    end
    idle("R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule